// File: doc/BRIEF.md
# Test Vector Sequencer Master

This block is a bus master for test mode. Once reset is released it asks a test interface controller for access with a two-wire request code and then waits for the controller's acknowledge line. While the block holds test mode, it takes vectors from a valid/ready stream and presents each one as a phase toward the controller. A phase is an address, a write of data, a read with an expected value and a mask, or an end marker. An address phase normally comes before each data phase. An end marker is preceded by a final address-type vector.

Read data returns a fixed number of cycles after the read phase is issued. A short pipeline holds the expected value and mask of every outstanding read, so each returned word is checked against the vector that asked for it. Bits outside the mask are not compared. A mismatch gives a one-cycle pulse, increments a saturating error counter and sets a sticky flag. If halt-on-mismatch is on, the first mismatch ends the run at once. Otherwise the vector list runs to its end marker. The block then drops both request lines and pulses `done`.

The vector stream follows the usual valid/ready rules. A vector is taken on a rising edge where `vec_valid` and `vec_ready` are both high. `vec_ready` is high only while test mode is held and the controller's acknowledge is high. The source must keep a vector and its fields stable until it is taken. Back-pressure from the controller reaches the source directly through `vec_ready`, and the block stores no vectors.

Top module: `tvseq_master`

## Requirements
- R1: During synchronous reset (rst_n low) the block drives both request lines low, `vec_ready` low, `err_count` zero, and `err_flag`, `mismatch`, `done` and `phase_strobe` low.
- R2: After reset the block drives request code A=1, B=0 and holds it until `ack` is seen high. The code A=0, B=1 never appears.
- R3: No vector is accepted before `ack` has granted test mode, or in any cycle in which `ack` is low. `vec_ready` is low in all such cycles.
- R4: While test mode is held (from the grant until the run ends) both request lines are high.
- R5: A vector accepted on an edge is presented during the next cycle: `phase_strobe` high for one cycle, `phase_kind` equal to its kind and `phase_word` equal to its word. The kind encoding is 0 address, 1 write, 2 read, 3 end.
- R6: A read vector is a mismatch exactly when ((rd_data XOR expected) AND mask) is nonzero. Bits outside the mask never cause a mismatch.
- R7: `rd_data` for a read accepted on edge t is sampled on edge t+RD_LAT. `mismatch` is high in the cycle after that edge and low before it.
- R8: Each mismatch increments `err_count` by one. The counter stops at its all-ones value.
- R9: `err_flag` goes high with the first mismatch and stays high until reset.
- R10: After an end vector, no further vectors are accepted. The block waits until every outstanding read has been compared, then pulses `done` for one cycle and drives both request lines low from then on.
- R11: With `halt_on_mismatch` low, sequencing continues after a mismatch. With it high, `vec_ready` falls in the cycle the mismatch is detected, at most RD_LAT-1 vectors are accepted after the failing read, and test mode is released with a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt_on_mismatch | input | 1 | Stop the run at the first mismatch |
| vec_valid | input | 1 | Vector stream valid |
| vec_ready | output | 1 | Vector stream ready |
| vec_kind | input | 2 | Vector kind: 0 address, 1 write, 2 read, 3 end |
| vec_word | input | DW | Address or write data |
| vec_expect | input | DW | Expected read value |
| vec_mask | input | DW | Read compare mask |
| req_a | output | 1 | Request line A |
| req_b | output | 1 | Request line B |
| ack | input | 1 | Controller acknowledge / ready |
| phase_strobe | output | 1 | One-cycle marker of a new phase |
| phase_kind | output | 2 | Kind of the current phase |
| phase_word | output | DW | Word of the current phase |
| rd_data | input | DW | Read data returned by the system |
| mismatch | output | 1 | One-cycle pulse on a read mismatch |
| err_count | output | CNT_W | Saturating mismatch count |
| err_flag | output | 1 | Sticky mismatch flag |
| done | output | 1 | One-cycle pulse when test mode ends |

## Verification
If the read pipeline loses, shifts or confuses an entry, `mismatch` fires in the wrong cycle, or fires for a read whose masked bits agree. That shows at the ports within RD_LAT+1 cycles of the read being accepted. A wrong sequencer state shows up on the request code or `vec_ready` in the very next cycle. It also shows as a `done` pulse that comes before the last outstanding comparison, or too many vectors taken after a halting mismatch. A wrong counter shows in `err_count` after the mismatch that it miscounts. A small counter width lets a saturation fault appear within a few dozen reads.

// File: rtl/tvseq_pkg.sv
`timescale 1ns/1ps
package tvseq_pkg;
  typedef enum logic [1:0] {
    VK_ADDR  = 2'd0,
    VK_WRITE = 2'd1,
    VK_READ  = 2'd2,
    VK_END   = 2'd3
  } vec_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RUN,
    ST_DRAIN,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/tvseq_handshake.sv
`timescale 1ns/1ps
module tvseq_handshake
  import tvseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack,
  input  logic       vec_valid,
  input  logic [1:0] vec_kind,
  input  logic       pipe_busy,
  input  logic       halt_hit,
  output logic       vec_ready,
  output logic       accept,
  output logic       req_a,
  output logic       req_b,
  output logic       done
);
  seq_state_e state;

  assign vec_ready = (state == ST_RUN) && ack && !halt_hit;
  assign accept    = vec_ready && vec_valid;

  always_comb begin
    req_a = 1'b0;
    req_b = 1'b0;
    unique case (state)
      ST_REQ:            req_a = 1'b1;
      ST_RUN, ST_DRAIN: begin req_a = 1'b1; req_b = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: state <= ST_REQ;
        ST_REQ:  if (ack) state <= ST_RUN;
        ST_RUN: begin
          if (halt_hit) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end else if (accept && vec_kind == VK_END) begin
            state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (halt_hit || !pipe_busy) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  // R2: the code A low / B high is never driven
  a_r2_no_b_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_b |-> req_a);
  // R10: the done pulse is followed by a released request code
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!req_a && !req_b && !done));
endmodule

// File: rtl/tvseq_rdpipe.sv
`timescale 1ns/1ps
module tvseq_rdpipe #(
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_exp,
  input  logic [DW-1:0] push_mask,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          hit,
  output logic          mism
);
  localparam int LAST = LAT - 1;

  logic [LAT-1:0] vld;
  logic [DW-1:0]  exp_q  [LAT];
  logic [DW-1:0]  mask_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) vld[0] <= 1'b0;
    else                 vld[0] <= push;
    if (push) begin
      exp_q[0]  <= push_exp;
      mask_q[0] <= push_mask;
    end
  end

  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n || flush) vld[i] <= 1'b0;
      else                 vld[i] <= vld[i-1];
      exp_q[i]  <= exp_q[i-1];
      mask_q[i] <= mask_q[i-1];
    end
  end

  assign busy = |vld;
  assign hit  = vld[LAST] && (((rd_data ^ exp_q[LAST]) & mask_q[LAST]) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) mism <= 1'b0;
    else        mism <= hit;
  end

  // R7: a mismatch pulse only follows a read that reached the sample stage
  a_r7_from_stage: assert property (@(posedge clk) disable iff (!rst_n)
    mism |-> $past(vld[LAST]));
  // R7: a push shows the pipeline as busy on the next cycle
  a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |=> busy);
endmodule

// File: rtl/tvseq_errcnt.sv
`timescale 1ns/1ps
module tvseq_errcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         flag
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      flag  <= 1'b0;
    end else if (inc) begin
      flag <= 1'b1;
      if (count != MAXV) count <= count + ONE;
    end
  end

  // R8: saturated counter never wraps
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAXV) |=> (count == MAXV));
  // R8: below the limit each increment adds exactly one
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count != MAXV) |=> (count == $past(count) + ONE));
  // R9: flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> flag);
endmodule

// File: rtl/tvseq_master.sv
`timescale 1ns/1ps
module tvseq_master
  import tvseq_pkg::*;
#(
  parameter int DW     = 32,
  parameter int RD_LAT = 3,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_on_mismatch,
  input  logic             vec_valid,
  output logic             vec_ready,
  input  logic [1:0]       vec_kind,
  input  logic [DW-1:0]    vec_word,
  input  logic [DW-1:0]    vec_expect,
  input  logic [DW-1:0]    vec_mask,
  output logic             req_a,
  output logic             req_b,
  input  logic             ack,
  output logic             phase_strobe,
  output logic [1:0]       phase_kind,
  output logic [DW-1:0]    phase_word,
  input  logic [DW-1:0]    rd_data,
  output logic             mismatch,
  output logic [CNT_W-1:0] err_count,
  output logic             err_flag,
  output logic             done
);
  logic accept, pipe_busy, hit, halt_hit, push_rd;

  assign halt_hit = halt_on_mismatch && hit;
  assign push_rd  = accept && (vec_kind == VK_READ);

  tvseq_handshake u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .vec_valid (vec_valid),
    .vec_kind  (vec_kind),
    .pipe_busy (pipe_busy),
    .halt_hit  (halt_hit),
    .vec_ready (vec_ready),
    .accept    (accept),
    .req_a     (req_a),
    .req_b     (req_b),
    .done      (done)
  );

  tvseq_rdpipe #(.DW(DW), .LAT(RD_LAT)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (halt_hit),
    .push      (push_rd),
    .push_exp  (vec_expect),
    .push_mask (vec_mask),
    .rd_data   (rd_data),
    .busy      (pipe_busy),
    .hit       (hit),
    .mism      (mismatch)
  );

  tvseq_errcnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (hit),
    .count (err_count),
    .flag  (err_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_strobe <= 1'b0;
      phase_kind   <= '0;
      phase_word   <= '0;
    end else begin
      phase_strobe <= accept;
      if (accept) begin
        phase_kind <= vec_kind;
        phase_word <= vec_word;
      end
    end
  end

  // R3: controller back-pressure blocks the stream
  a_r3_no_accept_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> !vec_ready);
  // R5: every accepted vector is presented next cycle
  a_r5_present: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> (phase_strobe && phase_kind == $past(vec_kind)));
  // R11: a halting mismatch releases test mode on the next cycle
  a_r11_halt_release: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_on_mismatch && hit) |=> (!req_a && !req_b && done));
  // R10: no vector is taken once the run is over
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !vec_ready);
endmodule

// File: tb/tvseq_master_bench.sv
`timescale 1ns/1ps
module tvseq_master_bench;
  localparam int DW = 32;
  localparam int LAT = 3;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_on_mismatch = 1'b0;
  logic vec_valid = 1'b0;
  logic vec_ready;
  logic [1:0] vec_kind = 2'd0;
  logic [DW-1:0] vec_word = '0, vec_expect = '0, vec_mask = '0;
  logic req_a, req_b;
  logic ack = 1'b0;
  logic phase_strobe;
  logic [1:0] phase_kind;
  logic [DW-1:0] phase_word;
  logic [DW-1:0] rd_data = '0;
  logic mismatch;
  logic [CW-1:0] err_count;
  logic err_flag, done;

  int tests = 0;
  int fails = 0;
  int model_cnt = 0;

  always #10 clk = ~clk;

  tvseq_master #(.DW(DW), .RD_LAT(LAT), .CNT_W(CW)) u_tvseq_master (
    .clk(clk), .rst_n(rst_n), .halt_on_mismatch(halt_on_mismatch),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_kind(vec_kind),
    .vec_word(vec_word), .vec_expect(vec_expect), .vec_mask(vec_mask),
    .req_a(req_a), .req_b(req_b), .ack(ack),
    .phase_strobe(phase_strobe), .phase_kind(phase_kind), .phase_word(phase_word),
    .rd_data(rd_data), .mismatch(mismatch), .err_count(err_count),
    .err_flag(err_flag), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // caller is just after a negedge; returns at the negedge after the accepting edge
  task automatic send(input logic [1:0] k, input logic [31:0] w, input logic [31:0] e, input logic [31:0] m);
    vec_valid = 1'b1; vec_kind = k; vec_word = w; vec_expect = e; vec_mask = m;
    while (!vec_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    vec_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ack = 1'b0; vec_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic enter_test();
    repeat (2) @(negedge clk);
    chk(req_a && !req_b, "R2 request code 10", {req_a, req_b}, 2'b10);
    ack = 1'b1;
    @(negedge clk);
    chk(req_a && req_b, "R4 run code 11", {req_a, req_b}, 2'b11);
  endtask

  // one read checked for exact pulse timing and masked result
  task automatic read_check(input logic [31:0] act, input logic [31:0] e, input logic [31:0] m);
    bit expm;
    expm = ((act ^ e) & m) != 0;
    rd_data = act;
    send(2'd0, 32'h8000_0600, '0, '0);
    send(2'd2, '0, e, m);
    repeat (LAT - 1) @(negedge clk);
    chk(mismatch == 1'b0, "R7 no pulse before sample edge", mismatch, 0);
    @(negedge clk);
    chk(mismatch == expm, "R6 masked compare", mismatch, expm);
    if (expm) model_cnt++;
    @(negedge clk);
    chk(err_count == ((model_cnt > CMAX) ? CMAX : model_cnt), "R8 count", err_count,
        (model_cnt > CMAX) ? CMAX : model_cnt);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int acc;
    int idx_m;
    int idx_d;
    int ndone;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(!req_a && !req_b && !vec_ready, "R1 idle outputs", {req_a, req_b, vec_ready}, 0);
    chk(err_count == 0 && !err_flag && !done && !mismatch && !phase_strobe, "R1 status",
        {err_count, err_flag, done, mismatch, phase_strobe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2/R3 hold off without ack
    vec_valid = 1'b1; vec_kind = 2'd0;
    for (int i = 0; i < 4; i++) begin
      chk(req_a && !req_b, "R2 request held", {req_a, req_b}, 2'b10);
      chk(!vec_ready && !phase_strobe, "R3 no accept before grant", {vec_ready, phase_strobe}, 0);
      @(negedge clk);
    end
    vec_valid = 1'b0;
    ack = 1'b1;
    @(negedge clk);
    chk(req_a && req_b, "R4 run code 11", {req_a, req_b}, 2'b11);
    // R5 address and write presentation
    send(2'd0, 32'h8000_0614, '0, '0);
    chk(phase_strobe && phase_kind == 2'd0 && phase_word == 32'h8000_0614, "R5 address phase",
        phase_word, 32'h8000_0614);
    @(negedge clk);
    chk(!phase_strobe, "R5 strobe one cycle", phase_strobe, 0);
    send(2'd1, 32'h0000_0005, '0, '0);
    chk(phase_strobe && phase_kind == 2'd1 && phase_word == 32'h5, "R5 write phase", phase_word, 32'h5);
    // R3 back-pressure mid-run
    ack = 1'b0; vec_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!vec_ready && !phase_strobe, "R3 ack low blocks", {vec_ready, phase_strobe}, 0);
    end
    vec_valid = 1'b0; ack = 1'b1;
    // R6/R7/R8 mask sweep; continuing after errors covers R11 with halt off
    for (int i = 0; i < 16; i++) read_check(32'h8000_0005, 32'h0, 32'(i));
    chk(err_count == 12, "R8 count after sweep", err_count, 12);
    chk(err_flag, "R9 flag set", err_flag, 1);
    read_check(32'h8000_0005, 32'h0, 32'h7FFF_FFF0);
    read_check(32'h8000_0005, 32'h0, 32'h8000_0000);
    read_check(32'h1234_5678, 32'h1234_5678, 32'hFFFF_FFFF);
    // back-to-back reads to saturate (R8)
    rd_data = 32'hFF;
    for (int i = 0; i < 6; i++) send(2'd2, '0, 32'h0, 32'h1);
    repeat (LAT + 2) @(negedge clk);
    chk(err_count == CMAX, "R8 saturation", err_count, CMAX);
    chk(err_flag, "R9 flag sticky", err_flag, 1);
    // R10 drain: read then end back to back
    send(2'd2, '0, 32'h0, 32'h1);
    send(2'd0, 32'h8000_0584, '0, '0);
    send(2'd3, '0, '0, '0);
    idx_m = -1; idx_d = -1; ndone = 0;
    vec_valid = 1'b1; vec_kind = 2'd0;
    for (int c = 0; c < 12; c++) begin
      if (mismatch && idx_m < 0) idx_m = c;
      if (done) begin ndone++; if (idx_d < 0) idx_d = c; end
      chk(!vec_ready, "R10 no accept after end", vec_ready, 0);
      @(negedge clk);
    end
    vec_valid = 1'b0;
    chk(ndone == 1, "R10 single done pulse", ndone, 1);
    chk(idx_m >= 0 && idx_d > idx_m, "R10 done after last compare", idx_d, idx_m + 1);
    chk(!req_a && !req_b, "R10 request released", {req_a, req_b}, 0);
    // R11 halt on mismatch
    do_reset();
    halt_on_mismatch = 1'b1;
    enter_test();
    rd_data = 32'h3;
    send(2'd2, '0, 32'h0, 32'h1);
    acc = 0; ndone = 0;
    vec_valid = 1'b1; vec_kind = 2'd0;
    for (int c = 0; c < 10; c++) begin
      if (vec_ready) acc++;
      if (done) ndone++;
      @(negedge clk);
    end
    vec_valid = 1'b0;
    chk(acc == LAT - 1, "R11 vectors after failing read", acc, LAT - 1);
    chk(ndone == 1, "R11 done on halt", ndone, 1);
    chk(!req_a && !req_b, "R11 test mode released", {req_a, req_b}, 0);
    chk(err_count == 1, "R11 R8 single error", err_count, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule